// File: doc/BRIEF.md
# Vector length set unit

This unit carries out the instruction that configures vector length. It keeps three pieces of architectural state: the maximum vector length (MVL), the current vector length (VL) and a vertical-first flag. A decoder supplies the fields of the instruction: a 7-bit immediate, three control bits (set-VL, set-MVL, vertical-first), the source and destination register selectors, and the record bit. The register file supplies the source operand and the count register value.

The immediate holds the length minus one, so a field of zero means a length of one. The requested length is taken from the source operand, from the count register, or from the immediate, depending on which selectors are zero. The requested length is clamped to the maximum length. When the record bit is set, the unit produces condition bits that describe the resulting VL, not the destination value. One of those bits reports that a clamp occurred.

Top module: `vlset_unit`

## Requirements
- R1: The length applied from the immediate is the 7-bit field plus one. A field of 0 gives 1 and a field of 127 gives 128.
- R2: With set-MVL high, MVL takes the immediate length. With set-VL high, VL is written. With both high and both selectors zero, VL and MVL end up equal.
- R3: The requested length comes from one of three sources. It is the source operand when the source selector is non-zero. It is the count register when the source selector is zero and the destination selector is non-zero. It is the immediate length when both selectors are zero.
- R4: The new VL is the minimum of the requested length and MVL, where MVL is the value after this operation. A request with any bit set above bit 7 counts as larger than MVL and is clamped.
- R5: With the record bit high, the overflow flag is 1 exactly when set-VL is high and the request exceeded MVL. Otherwise it is 0.
- R6: With the record bit high, the condition write strobe is asserted. The equal flag is 1 when the resulting VL is 0, and the greater-or-equal flag is 1 when the resulting VL is non-zero. This holds even when the destination selector is 0. With the record bit low, no condition write is signalled.
- R7: When any of the three control bits is high, the vertical-first flag takes the value of the vertical-first bit.
- R8: When all three control bits are low, VL, MVL and the vertical-first flag keep their values, and the destination result is the current VL.
- R9: Reset clears VL, MVL, the vertical-first flag and the result strobe.
- R10: The results are valid for exactly one cycle, in the cycle after a one-cycle operation strobe. The state registers change on that same edge. The destination result is the VL after the operation, zero-extended to 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_valid | input | 1 | One-cycle strobe that starts an operation |
| op_imm | input | 7 | Immediate field, length minus one |
| op_vs | input | 1 | Write VL |
| op_vf | input | 1 | Vertical-first mode bit |
| op_ms | input | 1 | Write MVL from the immediate |
| op_ra_sel | input | 5 | Source register selector |
| op_rt_sel | input | 5 | Destination register selector |
| op_rc | input | 1 | Record bit, requests the condition bits |
| ra_value | input | 64 | Source operand value |
| ctr_value | input | 64 | Count register value |
| res_valid | output | 1 | Results valid |
| res_rt | output | 64 | Destination result, the VL after the operation |
| cr_wr | output | 1 | Condition bits valid for writing |
| cr_eq | output | 1 | Resulting VL is zero |
| cr_ge | output | 1 | Resulting VL is non-zero |
| cr_so | output | 1 | Request was clamped |
| mvl_out | output | 8 | Current MVL |
| vl_out | output | 8 | Current VL |
| vfirst_out | output | 1 | Vertical-first flag |

## Verification
Every result, every condition bit and every state update is due one clock edge after the operation strobe. The bench drives inputs on the falling edge and waits for one rising edge. It then samples on the following falling edge, where it checks the strobe is high and compares all outputs. It samples once more a full cycle later to confirm the strobe has dropped. Before that rising edge, the bench also checks that the state has not yet changed.

// File: rtl/vlset_pkg.sv
package vlset_pkg;
   typedef enum logic [1:0] {
      SRC_REG = 2'd0,
      SRC_CTR = 2'd1,
      SRC_IMM = 2'd2
   } len_src_e;

   typedef struct packed {
      logic eq;
      logic ge;
      logic so;
   } cr_bits_t;
endpackage

// File: rtl/vlset_src_sel.sv
module vlset_src_sel
   import vlset_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int IMM_W = 7,
   parameter int SEL_W = 5
) (
   input  logic [IMM_W-1:0] imm,
   input  logic [SEL_W-1:0] ra_sel,
   input  logic [SEL_W-1:0] rt_sel,
   input  logic [XLEN-1:0]  ra_value,
   input  logic [XLEN-1:0]  ctr_value,
   output logic [XLEN-1:0]  req_len,
   output len_src_e         src
);
   localparam int LEN_W = IMM_W + 1;

   logic [LEN_W-1:0] imm_len;
   assign imm_len = {1'b0, imm} + LEN_W'(1);

   always_comb begin
      if (ra_sel != '0)      src = SRC_REG;
      else if (rt_sel != '0) src = SRC_CTR;
      else                   src = SRC_IMM;
   end

   always_comb begin
      unique case (src)
         SRC_REG: req_len = ra_value;
         SRC_CTR: req_len = ctr_value;
         default: req_len = {{(XLEN-LEN_W){1'b0}}, imm_len};
      endcase
   end
endmodule

// File: rtl/vlset_clamp.sv
module vlset_clamp #(
   parameter int XLEN = 64,
   parameter int VL_W = 8
) (
   input  logic [XLEN-1:0] req_len,
   input  logic [VL_W-1:0] limit,
   output logic [VL_W-1:0] len,
   output logic            over
);
   generate
      if (XLEN > VL_W) begin : g_wide
         logic hi_set;
         assign hi_set = |req_len[XLEN-1:VL_W];
         assign over   = hi_set || (req_len[VL_W-1:0] > limit);
         assign len    = over ? limit : req_len[VL_W-1:0];
      end else begin : g_narrow
         logic [VL_W-1:0] req_ext;
         assign req_ext = VL_W'(req_len);
         assign over    = req_ext > limit;
         assign len     = over ? limit : req_ext;
      end
   endgenerate
endmodule

// File: rtl/vlset_cr_gen.sv
module vlset_cr_gen
   import vlset_pkg::*;
#(
   parameter int VL_W = 8
) (
   input  logic [VL_W-1:0] vl_res,
   input  logic            clamped,
   output cr_bits_t        cr
);
   always_comb begin
      cr.eq = (vl_res == '0);
      cr.ge = (vl_res != '0);
      cr.so = clamped;
   end
endmodule

// File: rtl/vlset_unit.sv
module vlset_unit
   import vlset_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int IMM_W = 7,
   parameter int SEL_W = 5,
   parameter int VL_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [IMM_W-1:0] op_imm,
   input  logic             op_vs,
   input  logic             op_vf,
   input  logic             op_ms,
   input  logic [SEL_W-1:0] op_ra_sel,
   input  logic [SEL_W-1:0] op_rt_sel,
   input  logic             op_rc,
   input  logic [XLEN-1:0]  ra_value,
   input  logic [XLEN-1:0]  ctr_value,
   output logic             res_valid,
   output logic [XLEN-1:0]  res_rt,
   output logic             cr_wr,
   output logic             cr_eq,
   output logic             cr_ge,
   output logic             cr_so,
   output logic [VL_W-1:0]  mvl_out,
   output logic [VL_W-1:0]  vl_out,
   output logic             vfirst_out
);
   localparam int LEN_W = IMM_W + 1;

   generate
      if (VL_W < LEN_W) begin : g_chk_vl
         $error("VL_W too narrow for the immediate length");
      end
      if (XLEN <= LEN_W) begin : g_chk_xlen
         $error("XLEN must exceed the immediate length width");
      end
   endgenerate

   logic [VL_W-1:0] mvl_q, vl_q;
   logic            vf_q, res_valid_q, cr_wr_q;
   logic [XLEN-1:0] res_rt_q;
   cr_bits_t        cr_q;

   logic [XLEN-1:0] req_len;
   len_src_e        src;
   logic [VL_W-1:0] mvl_nxt, clamp_len, vl_nxt;
   logic            over, clamped;
   cr_bits_t        cr_nxt;

   vlset_src_sel #(.XLEN(XLEN), .IMM_W(IMM_W), .SEL_W(SEL_W)) u_src (
      .imm(op_imm), .ra_sel(op_ra_sel), .rt_sel(op_rt_sel),
      .ra_value(ra_value), .ctr_value(ctr_value),
      .req_len(req_len), .src(src)
   );

   // MVL after this operation bounds the new VL (R4)
   assign mvl_nxt = op_ms ? VL_W'({1'b0, op_imm} + LEN_W'(1)) : mvl_q;

   vlset_clamp #(.XLEN(XLEN), .VL_W(VL_W)) u_clamp (
      .req_len(req_len), .limit(mvl_nxt), .len(clamp_len), .over(over)
   );

   assign vl_nxt  = op_vs ? clamp_len : vl_q;
   assign clamped = op_vs && over;

   vlset_cr_gen #(.VL_W(VL_W)) u_cr (
      .vl_res(vl_nxt), .clamped(clamped), .cr(cr_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mvl_q       <= '0;
         vl_q        <= '0;
         vf_q        <= 1'b0;
         res_valid_q <= 1'b0;
         cr_wr_q     <= 1'b0;
         res_rt_q    <= '0;
         cr_q        <= '0;
      end else begin
         res_valid_q <= op_valid;
         if (op_valid) begin
            if (op_ms) mvl_q <= mvl_nxt;
            if (op_vs) vl_q  <= vl_nxt;
            if (op_vs || op_ms || op_vf) vf_q <= op_vf;
            res_rt_q <= {{(XLEN-VL_W){1'b0}}, vl_nxt};
            cr_wr_q  <= op_rc;
            cr_q     <= cr_nxt;
         end
      end
   end

   assign res_valid  = res_valid_q;
   assign res_rt     = res_rt_q;
   assign cr_wr      = res_valid_q && cr_wr_q;
   assign cr_eq      = cr_q.eq;
   assign cr_ge      = cr_q.ge;
   assign cr_so      = cr_q.so;
   assign mvl_out    = mvl_q;
   assign vl_out     = vl_q;
   assign vfirst_out = vf_q;

   p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> res_valid);
   p_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !res_valid);
   p_mvl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_ms) |=> (mvl_out == VL_W'({1'b0, $past(op_imm)}) + VL_W'(1)));
   p_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_vs) |=> (vl_out <= mvl_out));
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !op_vs && !op_ms && !op_vf)
      |=> ($stable(vl_out) && $stable(mvl_out) && $stable(vfirst_out)));
   p_eqge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cr_wr |-> (cr_eq != cr_ge));
   p_rt_r10: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_rt == {{(XLEN-VL_W){1'b0}}, vl_out}));
endmodule

// File: tb/vlset_unit_test.sv
`timescale 1ns/1ps
module vlset_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [6:0]  op_imm = '0;
   logic        op_vs = 1'b0, op_vf = 1'b0, op_ms = 1'b0, op_rc = 1'b0;
   logic [4:0]  op_ra_sel = '0, op_rt_sel = '0;
   logic [63:0] ra_value = '0, ctr_value = '0;
   logic        res_valid, cr_wr, cr_eq, cr_ge, cr_so, vfirst_out;
   logic [63:0] res_rt;
   logic [7:0]  mvl_out, vl_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   vlset_unit uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_imm(op_imm),
      .op_vs(op_vs), .op_vf(op_vf), .op_ms(op_ms), .op_ra_sel(op_ra_sel),
      .op_rt_sel(op_rt_sel), .op_rc(op_rc), .ra_value(ra_value),
      .ctr_value(ctr_value), .res_valid(res_valid), .res_rt(res_rt),
      .cr_wr(cr_wr), .cr_eq(cr_eq), .cr_ge(cr_ge), .cr_so(cr_so),
      .mvl_out(mvl_out), .vl_out(vl_out), .vfirst_out(vfirst_out)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // drive one operation at a falling edge, sample the result one edge later
   task automatic do_op(input logic [6:0] imm, input logic vs, input logic vf,
                        input logic ms, input logic [4:0] ra, input logic [4:0] rt,
                        input logic rc, input logic [63:0] rav, input logic [63:0] ctr);
      @(negedge clk);
      op_valid = 1'b1; op_imm = imm; op_vs = vs; op_vf = vf; op_ms = ms;
      op_ra_sel = ra; op_rt_sel = rt; op_rc = rc; ra_value = rav; ctr_value = ctr;
      @(posedge clk);
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   task automatic t_reset;
      chk("R9 vl", vl_out, 0);
      chk("R9 mvl", mvl_out, 0);
      chk("R9 vfirst", vfirst_out, 0);
      chk("R9 res_valid", res_valid, 0);
   endtask

   task automatic t_timing;
      @(negedge clk);
      op_valid = 1'b1; op_ms = 1'b1; op_vs = 1'b0; op_vf = 1'b0; op_imm = 7'd7;
      op_ra_sel = '0; op_rt_sel = '0; op_rc = 1'b0;
      #1;
      chk("R10 no early mvl", mvl_out, 0);
      chk("R10 no early valid", res_valid, 0);
      @(posedge clk);
      @(negedge clk);
      op_valid = 1'b0;
      chk("R10 valid due", res_valid, 1);
      chk("R1 mvl imm7", mvl_out, 8);
      chk("R2 vl untouched", vl_out, 0);
      @(negedge clk);
      chk("R10 valid one cycle", res_valid, 0);
   endtask

   task automatic t_both;
      do_op(7'd0, 1, 0, 1, 0, 0, 1, 64'd0, 64'd0);
      chk("R1 mvl imm0", mvl_out, 1);
      chk("R2 vl imm0", vl_out, 1);
      chk("R6 ge", cr_ge, 1);
      chk("R6 eq", cr_eq, 0);
      do_op(7'd127, 1, 0, 1, 0, 0, 1, 64'd0, 64'd0);
      chk("R1 mvl imm127", mvl_out, 128);
      chk("R2 vl imm127", vl_out, 128);
      chk("R5 so clear", cr_so, 0);
      chk("R10 rt", res_rt, 128);
   endtask

   task automatic t_sources;
      do_op(7'd3, 1, 0, 0, 5'd3, 5'd4, 1, 64'd50, 64'd20);
      chk("R3 reg src", vl_out, 50);
      chk("R10 rt reg", res_rt, 50);
      do_op(7'd3, 1, 0, 0, 5'd0, 5'd5, 1, 64'd99, 64'd20);
      chk("R3 ctr src", vl_out, 20);
      do_op(7'd9, 1, 0, 0, 5'd0, 5'd0, 1, 64'd99, 64'd77);
      chk("R3 imm src", vl_out, 10);
   endtask

   task automatic t_clamp;
      do_op(7'd7, 0, 0, 1, 0, 0, 0, 64'd0, 64'd0);
      chk("R8 vl kept by ms", vl_out, 10);
      do_op(7'd0, 1, 0, 0, 5'd2, 5'd1, 1, 64'd9, 64'd0);
      chk("R4 clamp", vl_out, 8);
      chk("R5 so set", cr_so, 1);
      do_op(7'd0, 1, 0, 0, 5'd2, 5'd1, 1, 64'h100_0000_0003, 64'd0);
      chk("R4 wide clamp", vl_out, 8);
      chk("R5 wide so", cr_so, 1);
      do_op(7'd0, 1, 0, 0, 5'd2, 5'd1, 1, 64'd8, 64'd0);
      chk("R4 equal", vl_out, 8);
      chk("R5 so equal", cr_so, 0);
      do_op(7'd0, 1, 0, 0, 5'd0, 5'd1, 1, 64'd0, 64'd100);
      chk("R4 ctr clamp", vl_out, 8);
      chk("R5 ctr so", cr_so, 1);
      do_op(7'd63, 1, 0, 1, 5'd2, 5'd1, 1, 64'd90, 64'd0);
      chk("R4 clamp new mvl", vl_out, 64);
   endtask

   task automatic t_cr;
      do_op(7'd0, 1, 0, 0, 5'd2, 5'd0, 1, 64'd0, 64'd0);
      chk("R6 vl zero", vl_out, 0);
      chk("R6 wr rt0", cr_wr, 1);
      chk("R6 eq zero", cr_eq, 1);
      chk("R6 ge zero", cr_ge, 0);
      do_op(7'd0, 1, 0, 0, 5'd2, 5'd0, 0, 64'd5, 64'd0);
      chk("R6 no wr rc0", cr_wr, 0);
      chk("R6 vl 5", vl_out, 5);
   endtask

   task automatic t_vf_get;
      do_op(7'd0, 1, 1, 0, 5'd2, 5'd1, 0, 64'd5, 64'd0);
      chk("R7 vf set", vfirst_out, 1);
      do_op(7'd33, 0, 0, 0, 5'd2, 5'd7, 1, 64'd40, 64'd30);
      chk("R8 vf held", vfirst_out, 1);
      chk("R8 vl held", vl_out, 5);
      chk("R8 mvl held", mvl_out, 64);
      chk("R8 rt vl", res_rt, 5);
      chk("R8 so clear", cr_so, 0);
      do_op(7'd15, 0, 0, 1, 0, 0, 0, 64'd0, 64'd0);
      chk("R7 vf cleared", vfirst_out, 0);
      chk("R7 mvl 16", mvl_out, 16);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_timing();
      t_both();
      t_sources();
      t_clamp();
      t_cr();
      t_vf_get();
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (5000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule